// File: doc/BRIEF.md
# NAND Flash Host Register Interface

This block sits between a host byte bus and the raw control pins of a NAND flash device. The host sees a window of eight byte registers. A write to the control register sets the command-latch, address-latch, chip-select and write-protect pins and sends a command to an external ECC engine. A data-port access moves one byte to or from the 8-bit flash I/O bus and pulses a read or write strobe.

A pair of interrupt registers, pending and enable, drives one interrupt line. Bit 7 of the enable register gates the whole line. Every data-port write clears the pending bits that belong to an earlier transfer, but the lowest bit is kept. Host reads return data one cycle after the request, marked by a valid flag. A flash device model is not part of the block.

Top module: `nandhost_regif`

## Requirements
- R1: After reset the control, pending and enable registers read 0x00, `fl_ce_n` is 1, `fl_cle`, `fl_ale`, `fl_wp`, `ecc_enable`, `ecc_readout`, `ecc_reset` and `irq` are 0.
- R2: A write to offset 4 stores the byte in the control register (read back at offset 4). From the next cycle on, bit 0 drives `fl_cle`, bit 1 drives `fl_ale` and bit 7 drives `fl_wp`.
- R3: `fl_ce_n` is the inverse of control bit 4: writing 1 to that bit selects the chip (`fl_ce_n` = 0).
- R4: Control bits [6:5] are an ECC command. 01 makes `ecc_enable` high, 10 makes `ecc_readout` high, and 11 and 00 make both low. `ecc_reset` is high for exactly the one cycle after each control write whose code is 01 or 11, and it stays low for 00 and 10.
- R5: A host write to any of offsets 0 to 3 places the byte on `fl_dout`, with `fl_wr_stb` high for exactly the next cycle.
- R6: A host read of any of offsets 0 to 3 raises `fl_rd_stb` during the request cycle and returns the byte present on `fl_din` in that cycle.
- R7: Offset 5 always reads 0x14. Writes to it change no register and no pin.
- R8: Offset 6 (pending) and offset 7 (enable) are byte registers that the host can both write and read back.
- R9: `irq` is high exactly when enable bit 7 is 1 and (enable AND pending) is nonzero.
- R10: A data-port write clears pending bits [7:1], keeps pending bit 0, and `irq` follows the new value from the next cycle.
- R11: `rd_valid` is high for the cycle after each host read, and `rd_data` holds the read value in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host byte write request |
| host_rd | input | 1 | Host byte read request |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after host_rd |
| fl_dout | output | 8 | Byte driven to flash I/O bus |
| fl_din | input | 8 | Byte from flash I/O bus |
| fl_wr_stb | output | 1 | One-cycle flash write strobe |
| fl_rd_stb | output | 1 | Flash read strobe, during the read request |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_wp | output | 1 | Write-protect pin level |
| ecc_enable | output | 1 | ECC engine enabled |
| ecc_readout | output | 1 | ECC result read-out selected |
| ecc_reset | output | 1 | One-cycle ECC reset pulse |
| irq | output | 1 | Interrupt output |

## Verification
The bench uses all four aliases of the data port. A decoder that matched only offset 0 would lose three writes and return stale read bytes. It checks the polarity of chip select, which a design driving the stored bit directly would get wrong. It walks all four ECC codes: a wrong decode would pulse reset on read-out or miss the pulse on the clear code. For the interrupt it checks an enable mask without bit 7, which must keep `irq` low even when the masked result is nonzero. It then makes a data write after all pending bits are set. A design that cleared everything would lose bit 0 and drop `irq`, and a design that cleared nothing would leave `irq` high.

// File: rtl/nandhost_pkg.sv
package nandhost_pkg;

    localparam int HOST_AW = 3;
    localparam int BYTE_W  = 8;

    localparam logic [HOST_AW-1:0] OFS_CTRL = 3'd4;
    localparam logic [HOST_AW-1:0] OFS_STAT = 3'd5;
    localparam logic [HOST_AW-1:0] OFS_PEND = 3'd6;
    localparam logic [HOST_AW-1:0] OFS_ENAB = 3'd7;

    typedef enum logic [1:0] {
        ECC_IDLE    = 2'b00,
        ECC_START   = 2'b01,
        ECC_READOUT = 2'b10,
        ECC_CLEAR   = 2'b11
    } ecc_cmd_e;

    // control register layout; the bit positions are what the pins decode
    typedef struct packed {
        logic     wp;
        ecc_cmd_e ecc;
        logic     cs;
        logic     spare3;
        logic     spare2;
        logic     ale;
        logic     cle;
    } ctrl_t;

    typedef struct packed {
        logic data;
        logic ctrl;
        logic stat;
        logic pend;
        logic enab;
    } sel_t;

    function automatic sel_t decode_ofs(input logic [HOST_AW-1:0] a);
        sel_t s;
        s.data = (a[HOST_AW-1] == 1'b0);
        s.ctrl = (a == OFS_CTRL);
        s.stat = (a == OFS_STAT);
        s.pend = (a == OFS_PEND);
        s.enab = (a == OFS_ENAB);
        return s;
    endfunction

    function automatic logic ecc_needs_reset(input ecc_cmd_e c);
        return (c == ECC_START) || (c == ECC_CLEAR);
    endfunction

endpackage

// File: rtl/nandhost_decode.sv
module nandhost_decode
    import nandhost_pkg::*;
(
    input  logic [HOST_AW-1:0] addr,
    output sel_t               sel
);
    always_comb sel = decode_ofs(addr);
endmodule

// File: rtl/nandhost_pins.sv
module nandhost_pins
    import nandhost_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output logic              fl_cle,
    output logic              fl_ale,
    output logic              fl_ce_n,
    output logic              fl_wp,
    output logic              ecc_enable,
    output logic              ecc_readout,
    output logic              ecc_reset
);
    ctrl_t wr_val;
    assign wr_val = ctrl_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            ecc_reset <= 1'b0;
        end else begin
            ecc_reset <= wr_ctrl && ecc_needs_reset(wr_val.ecc);
            if (wr_ctrl) ctrl_q <= wr_val;
        end
    end

    assign fl_cle      = ctrl_q.cle;
    assign fl_ale      = ctrl_q.ale;
    assign fl_ce_n     = ~ctrl_q.cs;
    assign fl_wp       = ctrl_q.wp;
    assign ecc_enable  = (ctrl_q.ecc == ECC_START);
    assign ecc_readout = (ctrl_q.ecc == ECC_READOUT);

    assert_ce_polarity_R3: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (fl_ce_n == !$past(wdata[4])));

    assert_ecc_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wdata[5]) |=> ecc_reset);

    assert_ecc_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> !ecc_reset);
endmodule

// File: rtl/nandhost_irq.sv
module nandhost_irq
    import nandhost_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_pend,
    input  logic              wr_enab,
    input  logic              wr_data,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] pend_q,
    output logic [BYTE_W-1:0] enab_q,
    output logic              irq
);
    localparam logic [BYTE_W-1:0] KEEP_MASK = BYTE_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            enab_q <= '0;
        end else begin
            if (wr_pend)      pend_q <= wdata;
            else if (wr_data) pend_q <= pend_q & KEEP_MASK;
            if (wr_enab)      enab_q <= wdata;
        end
    end

    assign irq = enab_q[BYTE_W-1] && |(enab_q & pend_q);

    assert_data_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_data && !wr_pend) |=> (pend_q[BYTE_W-1:1] == '0));

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_enab && !wdata[BYTE_W-1]) |=> !irq);
endmodule

// File: rtl/nandhost_regif.sv
module nandhost_regif
    import nandhost_pkg::*;
#(
    parameter logic [7:0] STATUS_VALUE = 8'h14
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [2:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    output logic [7:0] fl_dout,
    input  logic [7:0] fl_din,
    output logic       fl_wr_stb,
    output logic       fl_rd_stb,
    output logic       fl_cle,
    output logic       fl_ale,
    output logic       fl_ce_n,
    output logic       fl_wp,
    output logic       ecc_enable,
    output logic       ecc_readout,
    output logic       ecc_reset,
    output logic       irq
);
    sel_t              sel;
    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] pend_q;
    logic [BYTE_W-1:0] enab_q;
    logic              wr_data;

    nandhost_decode u_decode (
        .addr (host_addr),
        .sel  (sel)
    );

    assign wr_data = host_wr && sel.data;

    nandhost_pins u_pins (
        .clk         (clk),
        .rst         (rst),
        .wr_ctrl     (host_wr && sel.ctrl),
        .wdata       (host_wdata),
        .ctrl_q      (ctrl_q),
        .fl_cle      (fl_cle),
        .fl_ale      (fl_ale),
        .fl_ce_n     (fl_ce_n),
        .fl_wp       (fl_wp),
        .ecc_enable  (ecc_enable),
        .ecc_readout (ecc_readout),
        .ecc_reset   (ecc_reset)
    );

    nandhost_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .wr_pend (host_wr && sel.pend),
        .wr_enab (host_wr && sel.enab),
        .wr_data (wr_data),
        .wdata   (host_wdata),
        .pend_q  (pend_q),
        .enab_q  (enab_q),
        .irq     (irq)
    );

    // flash write path
    always_ff @(posedge clk) begin
        if (rst) begin
            fl_dout   <= '0;
            fl_wr_stb <= 1'b0;
        end else begin
            fl_wr_stb <= wr_data;
            if (wr_data) fl_dout <= host_wdata;
        end
    end

    // read strobe is issued in the request cycle; the byte is captured at its end
    assign fl_rd_stb = host_rd && sel.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= host_rd;
            if (host_rd) begin
                if (sel.data)      rd_data <= fl_din;
                else if (sel.ctrl) rd_data <= ctrl_q;
                else if (sel.stat) rd_data <= STATUS_VALUE;
                else if (sel.pend) rd_data <= pend_q;
                else               rd_data <= enab_q;
            end
        end
    end

    assert_wr_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        wr_data |=> (fl_wr_stb && fl_dout == $past(host_wdata)));

    assert_rd_valid_R11: assert property (@(posedge clk) disable iff (rst)
        host_rd |=> rd_valid);

    assert_rd_capture_R6: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr[2] == 1'b0) |=> (rd_data == $past(fl_din)));
endmodule

// File: tb/nandhost_regif_bench.sv
module nandhost_regif_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] rd_data, fl_dout, fl_din;
    logic rd_valid, fl_wr_stb, fl_rd_stb, fl_cle, fl_ale, fl_ce_n, fl_wp;
    logic ecc_enable, ecc_readout, ecc_reset, irq;
    logic [7:0] stub_byte = 8'h00;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    byte unsigned rd_exp_q[$];
    string        rd_tag_q[$];
    byte unsigned wr_exp_q[$];

    assign fl_din = stub_byte;

    always #(CLK_PERIOD/2) clk = ~clk;

    nandhost_regif u_nandhost_regif (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .fl_dout(fl_dout), .fl_din(fl_din),
        .fl_wr_stb(fl_wr_stb), .fl_rd_stb(fl_rd_stb),
        .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_ce_n(fl_ce_n), .fl_wp(fl_wp),
        .ecc_enable(ecc_enable), .ecc_readout(ecc_readout), .ecc_reset(ecc_reset),
        .irq(irq)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        if (a[2] == 1'b0) wr_exp_q.push_back(d);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        rd_exp_q.push_back(exp);
        rd_tag_q.push_back(req);
        #1;
        check({req, " rd strobe"}, int'(fl_rd_stb), int'(a[2] == 1'b0));
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    // monitor: pops expected items as the design produces them
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_valid) begin
                if (rd_exp_q.size() == 0) check("R11 unexpected rd_valid", 1, 0);
                else check(rd_tag_q.pop_front(), int'(rd_data), int'(rd_exp_q.pop_front()));
            end
            if (fl_wr_stb) begin
                if (wr_exp_q.size() == 0) check("R5 unexpected wr strobe", 1, 0);
                else check("R5 flash write byte", int'(fl_dout), int'(wr_exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 ce_n", int'(fl_ce_n), 1);
        check("R1 cle", int'(fl_cle), 0);
        check("R1 ale", int'(fl_ale), 0);
        check("R1 wp", int'(fl_wp), 0);
        check("R1 ecc", int'({ecc_enable, ecc_readout, ecc_reset}), 0);
        check("R1 irq", int'(irq), 0);
        host_read(3'd4, 8'h00, "R1 ctrl reset");
        host_read(3'd6, 8'h00, "R1 pend reset");
        host_read(3'd7, 8'h00, "R1 enab reset");
        host_read(3'd5, 8'h14, "R7 status const");

        // R2 / R3 pins
        host_write(3'd4, 8'h93);
        check("R2 cle", int'(fl_cle), 1);
        check("R2 ale", int'(fl_ale), 1);
        check("R2 wp", int'(fl_wp), 1);
        check("R3 ce_n selected", int'(fl_ce_n), 0);
        check("R4 no pulse on 00", int'(ecc_reset), 0);
        host_read(3'd4, 8'h93, "R2 ctrl readback");
        host_write(3'd4, 8'h0C);
        check("R3 ce_n deselected", int'(fl_ce_n), 1);
        check("R2 pins low", int'({fl_cle, fl_ale, fl_wp}), 0);

        // R4 ECC commands
        host_write(3'd4, 8'h20);
        check("R4 pulse on 01", int'(ecc_reset), 1);
        check("R4 enable on 01", int'(ecc_enable), 1);
        @(negedge clk);
        check("R4 pulse one cycle", int'(ecc_reset), 0);
        host_write(3'd4, 8'h40);
        check("R4 no pulse on 10", int'(ecc_reset), 0);
        check("R4 readout on 10", int'({ecc_enable, ecc_readout}), 1);
        host_write(3'd4, 8'h60);
        check("R4 pulse on 11", int'(ecc_reset), 1);
        check("R4 levels low on 11", int'({ecc_enable, ecc_readout}), 0);
        host_write(3'd4, 8'h00);
        check("R4 no pulse on 00 again", int'(ecc_reset), 0);

        // R5 data writes on all aliases
        for (int i = 0; i < 4; i++) host_write(3'(i), 8'hA0 + 8'(i));
        @(negedge clk);
        check("R5 strobe one cycle", int'(fl_wr_stb), 0);
        check("R5 all writes seen", wr_exp_q.size(), 0);

        // R6 / R11 data reads on all aliases
        for (int i = 0; i < 4; i++) begin
            stub_byte = 8'h5A ^ 8'(i * 17);
            host_read(3'(i), 8'h5A ^ 8'(i * 17), "R6 flash read byte");
        end

        // R7 status ignores writes
        host_write(3'd5, 8'hFF);
        host_read(3'd5, 8'h14, "R7 status after write");
        host_read(3'd4, 8'h00, "R7 ctrl untouched");
        check("R7 ce_n untouched", int'(fl_ce_n), 1);

        // R8 / R9
        host_write(3'd6, 8'hA5);
        host_read(3'd6, 8'hA5, "R8 pend readback");
        host_write(3'd7, 8'h3C);
        host_read(3'd7, 8'h3C, "R8 enab readback");
        check("R9 no global enable", int'(irq), 0);
        host_write(3'd7, 8'hA4);
        check("R9 enabled and pending", int'(irq), 1);
        host_write(3'd7, 8'h80);
        check("R9 bit7 source", int'(irq), 1);
        host_write(3'd6, 8'h00);
        check("R9 nothing pending", int'(irq), 0);

        // R10 data write keeps bit 0
        host_write(3'd6, 8'hFF);
        host_write(3'd7, 8'h81);
        check("R9 bit0 pending", int'(irq), 1);
        host_write(3'd1, 8'h77);
        check("R10 bit0 kept irq", int'(irq), 1);
        host_read(3'd6, 8'h01, "R10 pend after data write");
        host_write(3'd7, 8'h82);
        check("R10 bits cleared irq", int'(irq), 0);

        repeat (2) @(negedge clk);
        check("R11 all reads returned", rd_exp_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule